// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Bank

This block holds four independent down-counters behind a small memory-mapped register port. Channels 0 and 1 are 16 bits wide and channels 2 and 3 are 32 bits wide. Each channel has three parts: a reload register, a counter that moves down by one on each timer-clock enable pulse while the channel is enabled, and an interrupt flag. The flag is raised when the counter expires, and the counter then refills itself from the reload register.

Software writes a reload value, and the counter takes that value on the following timer pulse whether or not the channel is enabled. Counts are read through a latch. In live mode, each count read captures the addressed counter. In grouped mode, a read of the shared channel-0/1 word captures every counter at once, so later reads of the wide channels return values from that same instant.

A flag is cleared in one of two ways: by writing any data to the channel's clear address, or by writing zero to its bit in the control word. One interrupt line is the OR of all four flags.

Top module: `multi_timer_bank`

## Requirements
- R1: After reset, every counter, reload value, enable, flag and the latch-mode bit are zero, `irq` is low, and the control word at byte offset 0x00 reads 0.
- R2: Reload registers for channels 0..3 are at byte offsets 0x0C, 0x10, 0x14 and 0x18 and read back the written value. The 16-bit channels keep only bits 15..0 and read zero above them.
- R3: A reload write is copied into the counter on the next `tick` pulse, whether or not the channel is enabled. Without a pulse, the counter does not change.
- R4: On each `tick`, an enabled counter holding a value above 1 decrements by one. A disabled counter holds its value, and a counter holding 0 stays at 0.
- R5: A `tick` on an enabled counter holding 1 sets that channel's flag and refills the counter from its reload register.
- R6: `irq` is high exactly when at least one flag is set.
- R7: A write of any data to byte offset 0x30, 0x34, 0x38 or 0x3C clears the flag of channel 0, 1, 2 or 3 respectively.
- R8: A write to the control word clears each flag whose bit (bits 11..8, channel 0 at bit 8) is written 0 and leaves alone each flag written 1. When a flag is set and cleared in the same cycle, it ends up set.
- R9: Count words are at byte offset 0x20 (channel 1 in bits 31..16, channel 0 in bits 15..0), 0x24 (channel 2) and 0x28 (channel 3). Read data appears on `busRdata` in the cycle after `busRd` and carries the count of the read cycle.
- R10: With latch mode 0 (control bit 16 = 0), reads of 0x24 and 0x28 return the live count of the read cycle.
- R11: With latch mode 1, a read of 0x20 captures all four counts. Reads of 0x24 and 0x28 return the captured values until the next read of 0x20.
- R12: The control word reads back the enables in bits 3..0 (channel 0 at bit 0), the flags in bits 11..8, the latch mode in bit 16, and zero in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer-clock enable pulse, one cycle wide |
| busAddr | input | 8 | Byte offset of the access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | OR of all channel flags |

## Verification
The bench loads channels while they are disabled and checks that the counter changes only at the next pulse. A design that loaded only enabled channels, or loaded without waiting for a pulse, would read back the wrong count. It drives a control-word write that clears a flag on the same edge where that channel expires; a design in which the clear wins would drop the interrupt. It lets the counters move on after a grouped snapshot and confirms that the wide channels still return the captured values, while live mode returns the moved-on values. A design that ignored the latch mode would return moved-on counts in grouped mode.

// File: rtl/mtb_pkg.sv
package mtb_pkg;
  localparam int NUM_TMR  = 4;
  localparam int EN_LSB   = 0;
  localparam int FLAG_LSB = 8;
  localparam int LSEL_BIT = 16;

  localparam int OFS_CSR   = 'h00;
  localparam int OFS_LD0   = 'h0C;
  localparam int OFS_CNT12 = 'h20;
  localparam int OFS_CNT3  = 'h24;
  localparam int OFS_CNT4  = 'h28;
  localparam int OFS_CLR0  = 'h30;
  localparam int OFS_STEP  = 4;

  typedef enum logic [3:0] {
    RD_NONE, RD_CSR, RD_LD0, RD_LD1, RD_LD2, RD_LD3, RD_C12, RD_C3, RD_C4
  } rdSel_e;

  typedef struct packed {
    logic [NUM_TMR-1:0] ldWr;
    logic [NUM_TMR-1:0] clr;
    logic               rdEn;
    rdSel_e             rdSel;
    logic               snapAll;
  } strobe_t;
endpackage

// File: rtl/mtb_timer.sv
module mtb_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         en,
  input  logic         ldWr,
  input  logic [W-1:0] ldData,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic [W-1:0] ldVal,
  output logic         flag
);
  logic pend;
  logic expire;

  assign expire = tick && !pend && en && (cnt == W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      ldVal <= '0;
      pend  <= 1'b0;
      flag  <= 1'b0;
    end else begin
      if (ldWr) begin
        ldVal <= ldData;
        pend  <= 1'b1;
      end else if (tick) begin
        pend <= 1'b0;
      end
      if (tick) begin
        if (pend) begin
          cnt <= ldVal;
        end else if (en) begin
          if (cnt == W'(1)) cnt <= ldVal;
          else if (cnt != '0) cnt <= cnt - W'(1);
        end
      end
      if (expire) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  // R3
  load_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && pend) |=> (cnt == $past(ldVal)));

  // R3
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tick) |=> $stable(cnt));

  // R5
  expire_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !pend && en && cnt == W'(1)) |=> (flag && cnt == $past(ldVal)));

  // R8
  clear_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clr && !tick) |=> !flag);
endmodule

// File: rtl/mtb_ctrl.sv
module mtb_ctrl
  import mtb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWr,
  input  logic               busRd,
  input  logic [DATA_W-1:0]  busWdata,
  output strobe_t            strb,
  output logic [NUM_TMR-1:0] tmrEn,
  output logic               latchSel
);
  logic csrHit;

  assign csrHit = (busAddr == ADDR_W'(OFS_CSR));

  always_comb begin
    strb = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (busWr && busAddr == ADDR_W'(OFS_LD0 + OFS_STEP * i)) strb.ldWr[i] = 1'b1;
      if (busWr && busAddr == ADDR_W'(OFS_CLR0 + OFS_STEP * i)) strb.clr[i] = 1'b1;
      if (busWr && csrHit && !busWdata[FLAG_LSB + i]) strb.clr[i] = 1'b1;
    end
    strb.rdEn = busRd;
    if (csrHit) strb.rdSel = RD_CSR;
    else if (busAddr == ADDR_W'(OFS_LD0))                 strb.rdSel = RD_LD0;
    else if (busAddr == ADDR_W'(OFS_LD0 + OFS_STEP))      strb.rdSel = RD_LD1;
    else if (busAddr == ADDR_W'(OFS_LD0 + 2 * OFS_STEP))  strb.rdSel = RD_LD2;
    else if (busAddr == ADDR_W'(OFS_LD0 + 3 * OFS_STEP))  strb.rdSel = RD_LD3;
    else if (busAddr == ADDR_W'(OFS_CNT12))               strb.rdSel = RD_C12;
    else if (busAddr == ADDR_W'(OFS_CNT3))                strb.rdSel = RD_C3;
    else if (busAddr == ADDR_W'(OFS_CNT4))                strb.rdSel = RD_C4;
    else                                                  strb.rdSel = RD_NONE;
    strb.snapAll = busRd && latchSel && (busAddr == ADDR_W'(OFS_CNT12));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmrEn    <= '0;
      latchSel <= 1'b0;
    end else if (busWr && csrHit) begin
      tmrEn    <= busWdata[EN_LSB +: NUM_TMR];
      latchSel <= busWdata[LSEL_BIT];
    end
  end
endmodule

// File: rtl/mtb_datapath.sv
module mtb_datapath
  import mtb_pkg::*;
#(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int DATA_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  strobe_t            strb,
  input  logic [NUM_TMR-1:0] tmrEn,
  input  logic               latchSel,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irq
);
  logic [DATA_W-1:0]  cntBus [NUM_TMR];
  logic [DATA_W-1:0]  ldBus  [NUM_TMR];
  logic [DATA_W-1:0]  snap   [NUM_TMR];
  logic [NUM_TMR-1:0] flags;
  logic [DATA_W-1:0]  rdNext;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    localparam int W = (i < 2) ? NARROW_W : WIDE_W;
    logic [W-1:0] cntW;
    logic [W-1:0] ldW;

    mtb_timer #(.W(W)) u_tmr (
      .clk(clk), .rstN(rstN), .tick(tick), .en(tmrEn[i]),
      .ldWr(strb.ldWr[i]), .ldData(busWdata[W-1:0]), .clr(strb.clr[i]),
      .cnt(cntW), .ldVal(ldW), .flag(flags[i])
    );

    assign cntBus[i] = DATA_W'(cntW);
    assign ldBus[i]  = DATA_W'(ldW);

    always_ff @(posedge clk) begin
      if (!rstN) snap[i] <= '0;
      else if (strb.snapAll) snap[i] <= cntBus[i];
    end
  end

  assign irq = |flags;

  always_comb begin
    rdNext = '0;
    case (strb.rdSel)
      RD_CSR: begin
        rdNext[EN_LSB +: NUM_TMR]   = tmrEn;
        rdNext[FLAG_LSB +: NUM_TMR] = flags;
        rdNext[LSEL_BIT]            = latchSel;
      end
      RD_LD0: rdNext = ldBus[0];
      RD_LD1: rdNext = ldBus[1];
      RD_LD2: rdNext = ldBus[2];
      RD_LD3: rdNext = ldBus[3];
      RD_C12: begin
        rdNext[NARROW_W-1:0]          = cntBus[0][NARROW_W-1:0];
        rdNext[2*NARROW_W-1:NARROW_W] = cntBus[1][NARROW_W-1:0];
      end
      RD_C3:  rdNext = latchSel ? snap[2] : cntBus[2];
      RD_C4:  rdNext = latchSel ? snap[3] : cntBus[3];
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdata <= '0;
    else if (strb.rdEn) busRdata <= rdNext;
  end

  // R6
  irq_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tick) |=> !$rose(irq));
endmodule

// File: rtl/multi_timer_bank.sv
module multi_timer_bank
  import mtb_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  strobe_t            strb;
  logic [NUM_TMR-1:0] tmrEn;
  logic               latchSel;

  mtb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .strb(strb), .tmrEn(tmrEn), .latchSel(latchSel)
  );

  mtb_datapath #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .strb(strb), .tmrEn(tmrEn),
    .latchSel(latchSel), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );
endmodule

// File: tb/sim_multi_timer_bank.sv
module sim_multi_timer_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;
  int          total = 0;
  int          bad = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  multi_timer_bank u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d, input logic withTick = 1'b0);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1; tick = withTick;
    @(negedge clk);
    busWr = 1'b0; tick = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic testReset();
    busRead(8'h00, rv); check("R1 csr", rv, 32'h0);
    busRead(8'h20, rv); check("R1 cnt12", rv, 32'h0);
    busRead(8'h28, rv); check("R1 cnt4", rv, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic testReload();
    busWrite(8'h0C, 32'hABCD1234);
    busWrite(8'h18, 32'h89ABCDEF);
    busWrite(8'h14, 32'd5);
    busRead(8'h0C, rv); check("R2 ld0", rv, 32'h00001234);
    busRead(8'h18, rv); check("R2 ld3", rv, 32'h89ABCDEF);
  endtask

  task automatic testLoadDisabled();
    busRead(8'h24, rv); check("R3 no tick", rv, 32'h0);
    pulse(1);
    busRead(8'h24, rv); check("R3 loaded ch2", rv, 32'd5);
    busRead(8'h20, rv); check("R3 loaded ch0", rv, 32'h00001234);
  endtask

  task automatic testCount();
    busWrite(8'h00, 32'h4);
    pulse(2);
    busRead(8'h24, rv); check("R4 decrement", rv, 32'd3);
    busRead(8'h28, rv); check("R4 disabled hold", rv, 32'h89ABCDEF);
  endtask

  task automatic testExpire();
    pulse(2);
    busRead(8'h24, rv); check("R4 at one", rv, 32'd1);
    check("R6 irq low", {31'h0, irq}, 32'h0);
    pulse(1);
    busRead(8'h24, rv); check("R5 reload", rv, 32'd5);
    busRead(8'h00, rv); check("R5 flag", rv, 32'h404);
    check("R6 irq high", {31'h0, irq}, 32'h1);
  endtask

  task automatic testClearAddr();
    busWrite(8'h38, 32'h0);
    busRead(8'h00, rv); check("R7 cleared", rv, 32'h004);
    check("R7 irq", {31'h0, irq}, 32'h0);
    busWrite(8'h00, 32'h0);
  endtask

  task automatic testCsrClear();
    busWrite(8'h0C, 32'd1);
    pulse(1);
    busWrite(8'h00, 32'h1);
    pulse(1);
    busRead(8'h00, rv); check("R8 flag set", rv, 32'h101);
    busWrite(8'h00, 32'h101);
    busRead(8'h00, rv); check("R8 write one keeps", rv, 32'h101);
    busWrite(8'h00, 32'h001, 1'b1);
    busRead(8'h00, rv); check("R8 set wins", rv, 32'h101);
    busWrite(8'h00, 32'h000);
    busRead(8'h00, rv); check("R8 write zero clears", rv, 32'h000);
    check("R8 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic testPacking();
    busWrite(8'h0C, 32'h1111);
    busWrite(8'h10, 32'hFFFF2222);
    pulse(1);
    busRead(8'h20, rv); check("R9 packing", rv, 32'h22221111);
    busRead(8'h10, rv); check("R2 ld1 narrow", rv, 32'h00002222);
  endtask

  task automatic testLatch();
    busWrite(8'h14, 32'd100);
    busWrite(8'h18, 32'd200);
    pulse(1);
    busWrite(8'h00, 32'h1000C);
    busRead(8'h00, rv); check("R12 csr layout", rv, 32'h1000C);
    busRead(8'h20, rv);
    pulse(3);
    busRead(8'h24, rv); check("R11 snap ch2", rv, 32'd100);
    busRead(8'h28, rv); check("R11 snap ch3", rv, 32'd200);
    busWrite(8'h00, 32'h0000C);
    busRead(8'h24, rv); check("R10 live ch2", rv, 32'd97);
    busRead(8'h28, rv); check("R10 live ch3", rv, 32'd197);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testReload();
    testLoadDisabled();
    testCount();
    testExpire();
    testClearAddr();
    testCsrClear();
    testPacking();
    testLatch();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule